// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a word-organised serial EEPROM that answers a host over three wires: a select line, a serial clock and a serial data input, with a data output that has its own enable for a tri-state pad. All three inputs are sampled with the system clock through a parameterised synchroniser, and the serial clock is edge-detected in that domain. An instruction is a start bit, a two-bit command code and an address. It is followed by a data word for the commands that carry one.

The storage is a register array of `DEPTH` words of `DATA_W` bits. The array resets to the erased state of all ones. Programming is guarded by a write-enable latch that stays set across instructions. Every programming command starts a self-timed cycle of `PROG_CYCLES` system clocks. While that cycle runs, the host can deselect and then reselect the device to watch a ready/busy flag on the data output. Reads stream without limit: the address pointer advances after each word.

Top module: `sprom_slave`

## Requirements
- R1: While select is high and no instruction is in progress, data-input bits sampled as 0 on rising serial-clock edges are ignored. The first 1 is the start bit. It is followed by a two-bit code (MSB first) and `log2(DEPTH)` address bits (MSB first), all sampled on rising serial-clock edges.
- R2: Code 10 is a read and works whether or not writes are enabled. On the rising edge that samples the last address bit, the output is enabled and shows a single 0. The following rising edges show the addressed word MSB first. After reset every word reads as all ones.
- R3: While select stays high after the LSB of a read word, the next rising edge shows the MSB of the word at the next address, with no 0 inserted. The address wraps from `DEPTH-1` to 0.
- R4: Code 00 with the top two address bits at 11 sets the write-enable latch, and with 00 it clears the latch. The latch is clear after reset and keeps its value across instructions and deselects.
- R5: Code 01 writes the `DATA_W` bits that follow the address (MSB first) into the addressed word. The write happens on the edge that samples the last data bit, and the self-timed cycle starts there.
- R6: Code 11 sets every bit of the addressed word to 1 and leaves every other word unchanged.
- R7: Code 00 with the top address bits at 10 sets every word to all ones. Code 00 with 01, followed by a data word, writes that word into every location.
- R8: A write, erase, erase-all or write-all received while the latch is clear changes no word and starts no self-timed cycle.
- R9: After a programming instruction, if select is taken low and raised again while the cycle runs, the output is enabled and shows 0 while busy and 1 once the cycle of `PROG_CYCLES` clocks has ended. Data input is ignored until select falls again.
- R10: If select is raised only after the self-timed cycle has ended, no status is driven and the output stays disabled.
- R11: Dropping select before the last bit of an instruction aborts it, with no change to the array or the latch and no cycle started.
- R12: The output enable is low after reset, low one clock after the synchronised select is low, and low outside a read or a status phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Device select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the device |
| sdo_o | output | 1 | Serial data or ready/busy flag out of the device |
| sdo_en_o | output | 1 | Output enable for the data pad |

## Verification
The bench goes after the read boundaries. A design that inserts the leading 0 before every word shifts all later bits by one position. A design that fails to wrap the pointer reads past the array. It also goes after the status window. A design that shows status whenever select rises would drive the pad after the cycle had ended. A design that keeps decoding input during status would start a new instruction while busy. Locked programming commands, aborted writes and leading zeros before the start bit are each followed by read-back or status probing. This catches designs that change a word, start a cycle or lose alignment when they should not.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      EX_LOCK   = 2'b00,
      EX_FILL   = 2'b01,
      EX_WIPE   = 2'b10,
      EX_UNLOCK = 2'b11
   } ext_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_READ,
      ST_STATUS,
      ST_DONE
   } st_e;

endpackage

// File: rtl/sprom_pin_sync.sv
module sprom_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_in,
   input  logic sk_in,
   input  logic di_in,
   output logic cs_s,
   output logic di_s,
   output logic cs_rise,
   output logic sk_rise
);

   logic [2:0] raw;
   logic [2:0] synced;
   logic       cs_d;
   logic       sk_d;

   assign raw = {cs_in, sk_in, di_in};

   if (STAGES == 0) begin : g_direct
      assign synced = raw;
   end else begin : g_chain
      logic [STAGES-1:0][2:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign synced = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d <= 1'b0;
         sk_d <= 1'b0;
      end else begin
         cs_d <= synced[2];
         sk_d <= synced[1];
      end
   end

   assign cs_s    = synced[2];
   assign di_s    = synced[0];
   assign cs_rise = synced[2] & ~cs_d;
   assign sk_rise = synced[1] & ~sk_d;

endmodule

// File: rtl/sprom_timer.sv
module sprom_timer #(
   parameter int unsigned CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);  // R9
   AST_BUSY_TICKS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R9

endmodule

// File: rtl/sprom_array.sv
module sprom_array #(
   parameter int DEPTH = 1024,
   parameter int WIDTH = 16,
   parameter int AW    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_one,
   input  logic             wr_all,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] word_q [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[w] <= '1;
         end else if (wr_all || (wr_one && (wr_addr == AW'(w)))) begin
            word_q[w] <= wr_data;
         end
      end
   end

   assign rd_data = word_q[rd_addr];

   AST_SINGLE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_one && wr_all));  // R7

endmodule

// File: rtl/sprom_ctrl.sv
module sprom_ctrl
   import sprom_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          cs_rise,
   input  logic          sk_rise,
   input  logic          di_s,
   input  logic          busy_i,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          wr_one,
   output logic          wr_all,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          prog_start,
   output logic          dout,
   output logic          oe
);

   localparam int CNT_W = $clog2((AW > DW) ? AW : DW) + 1;
   localparam int BW    = $clog2(DW);

   st_e            state_q;
   op_e            op_q;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  data_q;
   logic           wen_q;
   logic [AW-1:0]  rd_addr_q;
   logic [BW-1:0]  bit_q;
   logic           dout_q;
   logic           oe_q;

   logic [AW-1:0]  full_addr;
   logic [DW-1:0]  full_data;
   ext_e           ext_code;
   logic           addr_done;
   logic           data_done;

   assign full_addr = {addr_q[AW-2:0], di_s};
   assign full_data = {data_q[DW-2:0], di_s};
   assign ext_code  = ext_e'(full_addr[AW-1 -: 2]);
   assign addr_done = sk_rise && (state_q == ST_ADDR) && (cnt_q == CNT_W'(AW-1));
   assign data_done = sk_rise && (state_q == ST_DATA) && (cnt_q == CNT_W'(DW-1));

   // Commit strobes toward the array, gated by select and the enable latch
   always_comb begin
      wr_one  = 1'b0;
      wr_all  = 1'b0;
      wr_addr = addr_q;
      wr_data = full_data;
      if (cs_s && wen_q) begin
         if (addr_done) begin
            if (op_q == OP_ERASE) begin
               wr_one  = 1'b1;
               wr_addr = full_addr;
               wr_data = '1;
            end else if (op_q == OP_EXT && ext_code == EX_WIPE) begin
               wr_all  = 1'b1;
               wr_data = '1;
            end
         end else if (data_done) begin
            if (op_q == OP_WRITE) begin
               wr_one = 1'b1;
            end else begin
               wr_all = 1'b1;
            end
         end
      end
   end

   assign prog_start = wr_one | wr_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= OP_EXT;
         cnt_q     <= '0;
         addr_q    <= '0;
         data_q    <= '0;
         wen_q     <= 1'b0;
         rd_addr_q <= '0;
         bit_q     <= '0;
         dout_q    <= 1'b0;
         oe_q      <= 1'b0;
      end else if (!cs_s) begin
         state_q <= ST_IDLE;
         oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cs_rise && busy_i) begin
                  state_q <= ST_STATUS;
                  oe_q    <= 1'b1;
                  dout_q  <= 1'b0;
               end else if (sk_rise && di_s && !busy_i) begin
                  state_q <= ST_OPC;
                  cnt_q   <= '0;
               end
            end
            ST_OPC: begin
               if (sk_rise) begin
                  op_q <= op_e'({op_q[0], di_s});
                  if (cnt_q == CNT_W'(1)) begin
                     state_q <= ST_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_ADDR: begin
               if (sk_rise) begin
                  addr_q <= full_addr;
                  if (addr_done) begin
                     cnt_q <= '0;
                     unique case (op_q)
                        OP_READ: begin
                           state_q   <= ST_READ;
                           rd_addr_q <= full_addr;
                           bit_q     <= '0;
                           oe_q      <= 1'b1;
                           dout_q    <= 1'b0;
                        end
                        OP_WRITE: state_q <= ST_DATA;
                        OP_ERASE: state_q <= ST_DONE;
                        default: begin
                           unique case (ext_code)
                              EX_UNLOCK: begin
                                 wen_q   <= 1'b1;
                                 state_q <= ST_DONE;
                              end
                              EX_LOCK: begin
                                 wen_q   <= 1'b0;
                                 state_q <= ST_DONE;
                              end
                              EX_FILL: state_q <= ST_DATA;
                              default: state_q <= ST_DONE;
                           endcase
                        end
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (sk_rise) begin
                  data_q <= full_data;
                  if (data_done) begin
                     state_q <= ST_DONE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_READ: begin
               if (sk_rise) begin
                  dout_q <= rd_data[BW'(DW-1) - bit_q];
                  if (bit_q == BW'(DW-1)) begin
                     bit_q     <= '0;
                     rd_addr_q <= rd_addr_q + 1'b1;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            ST_STATUS: begin
               dout_q <= ~busy_i;
            end
            ST_DONE: begin
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_addr = rd_addr_q;
   assign dout    = dout_q;
   assign oe      = oe_q;

   AST_DESELECT_RELEASES_DO: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !oe_q);  // R12
   AST_LOCKED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_i) |-> $past(wen_q));  // R8
   AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && $past(state_q) == ST_ADDR) |-> (oe_q && !dout_q));  // R2
   AST_LATE_SELECT_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && cs_s && cs_rise && !busy_i) |=> (state_q != ST_STATUS));  // R10
   AST_NO_DECODE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && state_q == ST_IDLE) |=> (state_q != ST_OPC));  // R9
   AST_STREAM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && cs_s && sk_rise && bit_q == BW'(DW-1))
         |=> (rd_addr_q == $past(rd_addr_q) + 1'b1));  // R3

endmodule

// File: rtl/sprom_slave.sv
module sprom_slave #(
   parameter int          DEPTH       = 1024,
   parameter int          DATA_W      = 16,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned PROG_CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic sdo_o,
   output logic sdo_en_o
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sprom_slave: DEPTH must be a power of two of at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("sprom_slave: DATA_W must be at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("sprom_slave: SYNC_STAGES must be 0 to 4");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("sprom_slave: PROG_CYCLES must be at least 1");
   end

   logic              cs_s;
   logic              di_s;
   logic              cs_rise;
   logic              sk_rise;
   logic              busy;
   logic              prog_start;
   logic              wr_one;
   logic              wr_all;
   logic [AW-1:0]     wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [AW-1:0]     rd_addr;
   logic [DATA_W-1:0] rd_data;

   sprom_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_in   (sel_i),
      .sk_in   (sclk_i),
      .di_in   (sdi_i),
      .cs_s    (cs_s),
      .di_s    (di_s),
      .cs_rise (cs_rise),
      .sk_rise (sk_rise)
   );

   sprom_ctrl #(.AW(AW), .DW(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (cs_s),
      .cs_rise    (cs_rise),
      .sk_rise    (sk_rise),
      .di_s       (di_s),
      .busy_i     (busy),
      .rd_data    (rd_data),
      .rd_addr    (rd_addr),
      .wr_one     (wr_one),
      .wr_all     (wr_all),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .prog_start (prog_start),
      .dout       (sdo_o),
      .oe         (sdo_en_o)
   );

   sprom_array #(.DEPTH(DEPTH), .WIDTH(DATA_W), .AW(AW)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_one  (wr_one),
      .wr_all  (wr_all),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   sprom_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (prog_start),
      .busy  (busy)
   );

endmodule

// File: tb/sprom_slave_test.sv
module sprom_slave_test;

   localparam int DEPTH = 1024;
   localparam int DW    = 16;
   localparam int AW    = 10;
   localparam int SYNC  = 2;
   localparam int PROG  = 300;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sk = 1'b0;
   logic sdi = 1'b0;
   logic sdo;
   logic sdo_en;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   string phase = "R12 reset";

   always #2 clk = ~clk;

   sprom_slave #(.DEPTH(DEPTH), .DATA_W(DW), .SYNC_STAGES(SYNC), .PROG_CYCLES(PROG)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (cs),
      .sclk_i   (sk),
      .sdi_i    (sdi),
      .sdo_o    (sdo),
      .sdo_en_o (sdo_en)
   );

   // ---------------- behavioural reference model ----------------
   localparam int M_IDLE = 0, M_OPC = 1, M_ADDR = 2, M_DATA = 3,
                  M_READ = 4, M_STAT = 5, M_DONE = 6;

   logic [DW-1:0] m_mem [DEPTH];
   bit [2:0]      hq [$];
   int            m_state, m_cnt, m_addr, m_busy, m_rptr, m_bit;
   logic [1:0]    m_op;
   logic [DW-1:0] m_data;
   bit            m_wen;
   logic          m_oe, m_do;

   task automatic model_reset();
      hq.delete();
      repeat (SYNC + 2) hq.push_back(3'b000);
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
      m_state = M_IDLE; m_cnt = 0; m_addr = 0; m_busy = 0; m_rptr = 0; m_bit = 0;
      m_op = 2'b00; m_data = '0; m_wen = 1'b0; m_oe = 1'b0; m_do = 1'b0;
   endtask

   task automatic model_step(input bit c, input bit crise, input bit krise, input bit d);
      bit busy_now = (m_busy != 0);
      bit start = 1'b0;
      int top;
      if (!c) begin
         m_state = M_IDLE;
         m_oe = 1'b0;
      end else begin
         case (m_state)
            M_IDLE: begin
               if (crise && busy_now) begin
                  m_state = M_STAT; m_oe = 1'b1; m_do = 1'b0;
               end else if (krise && d && !busy_now) begin
                  m_state = M_OPC; m_cnt = 0;
               end
            end
            M_OPC: if (krise) begin
               m_op = {m_op[0], d};
               m_cnt++;
               if (m_cnt == 2) begin m_state = M_ADDR; m_cnt = 0; m_addr = 0; end
            end
            M_ADDR: if (krise) begin
               m_addr = ((m_addr << 1) | int'(d)) & (DEPTH - 1);
               m_cnt++;
               if (m_cnt == AW) begin
                  m_cnt = 0;
                  m_state = M_DONE;
                  top = m_addr >> (AW - 2);
                  case (m_op)
                     2'b10: begin m_state = M_READ; m_rptr = m_addr; m_bit = 0; m_oe = 1'b1; m_do = 1'b0; end
                     2'b01: begin m_state = M_DATA; m_data = '0; end
                     2'b11: if (m_wen) begin m_mem[m_addr] = '1; start = 1'b1; end
                     default: begin
                        if (top == 3) m_wen = 1'b1;
                        else if (top == 0) m_wen = 1'b0;
                        else if (top == 1) begin m_state = M_DATA; m_data = '0; end
                        else if (m_wen) begin
                           for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
                           start = 1'b1;
                        end
                     end
                  endcase
               end
            end
            M_DATA: if (krise) begin
               m_data = {m_data[DW-2:0], d};
               m_cnt++;
               if (m_cnt == DW) begin
                  m_state = M_DONE;
                  if (m_wen) begin
                     if (m_op == 2'b01) m_mem[m_addr] = m_data;
                     else for (int i = 0; i < DEPTH; i++) m_mem[i] = m_data;
                     start = 1'b1;
                  end
               end
            end
            M_READ: if (krise) begin
               m_do = m_mem[m_rptr][DW-1-m_bit];
               m_bit++;
               if (m_bit == DW) begin m_bit = 0; m_rptr = (m_rptr + 1) % DEPTH; end
            end
            M_STAT: m_do = !busy_now;
            default: ;
         endcase
      end
      if (start) m_busy = PROG;
      else if (m_busy > 0) m_busy--;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit [2:0] smp, prv;
         hq.push_back({cs, sk, sdi});
         hq.delete(0);
         smp = hq[1];
         prv = hq[0];
         model_step(smp[2], smp[2] & ~prv[2], smp[1] & ~prv[1], smp[0]);
      end
   end

   // Per-clock comparison of the pad against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (sdo_en !== m_oe || (m_oe && sdo !== m_do)) begin
            fails++;
            $display("FAIL %s per-clock: en=%b do=%b expected en=%b do=%b",
                     phase, sdo_en, sdo, m_oe, m_do);
         end
      end
   end

   // ---------------- directed stimulus ----------------
   logic [DW-1:0] rbuf [4];
   logic          dummy_bit, dummy_en;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic d);
      sdi = d;
      sk  = 1'b0;
      repeat (HALF) @(negedge clk);
      sk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic select();
      sk = 1'b0;
      cs = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic deselect();
      sk  = 1'b0;
      sdi = 1'b0;
      cs  = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [1:0] op, input int addr);
      clk_bit(1'b1);
      clk_bit(op[1]);
      clk_bit(op[0]);
      for (int i = AW - 1; i >= 0; i--) clk_bit(addr[i]);
   endtask

   task automatic do_read(input int addr, input int nwords, input int zeros);
      select();
      for (int z = 0; z < zeros; z++) clk_bit(1'b0);
      send_hdr(2'b10, addr);
      dummy_bit = sdo;
      dummy_en  = sdo_en;
      for (int k = 0; k < nwords; k++) begin
         for (int b = 0; b < DW; b++) begin
            clk_bit(1'b0);
            rbuf[k] = {rbuf[k][DW-2:0], sdo};
         end
      end
      deselect();
   endtask

   task automatic prog(input logic [1:0] op, input int addr, input bit has_data, input logic [DW-1:0] data);
      select();
      send_hdr(op, addr);
      if (has_data) for (int i = DW - 1; i >= 0; i--) clk_bit(data[i]);
      deselect();
   endtask

   function automatic int ext_addr(input int code);
      return code << (AW - 2);
   endfunction

   task automatic settle();
      repeat (PROG + 20) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R12 enable low after reset", {15'd0, sdo_en}, 16'd0);

      phase = "R2 read after reset";
      do_read(3, 1, 0);
      chk("R2 leading zero", {15'd0, dummy_bit}, 16'd0);
      chk("R2 output enabled for leading zero", {15'd0, dummy_en}, 16'd1);
      chk("R2 erased word", rbuf[0], 16'hFFFF);

      phase = "R8 locked write";
      prog(2'b01, 5, 1'b1, 16'h1234);
      select();
      chk("R8 no status after locked write", {15'd0, sdo_en}, 16'd0);
      deselect();
      do_read(5, 1, 0);
      chk("R8 word unchanged", rbuf[0], 16'hFFFF);

      phase = "R9 write and status";
      prog(2'b00, ext_addr(3), 1'b0, '0);
      prog(2'b01, 5, 1'b1, 16'hA5C3);
      select();
      chk("R9 status enabled", {15'd0, sdo_en}, 16'd1);
      chk("R9 busy shows 0", {15'd0, sdo}, 16'd0);
      settle();
      chk("R9 ready shows 1", {15'd0, sdo}, 16'd1);
      send_hdr(2'b10, 5);
      chk("R9 input ignored in status", {15'd0, sdo_en, sdo}, 16'd3);
      deselect();
      chk("R12 enable low after deselect", {15'd0, sdo_en}, 16'd0);

      phase = "R5 read back";
      do_read(5, 1, 0);
      chk("R5 written word", rbuf[0], 16'hA5C3);

      phase = "R10 late select";
      prog(2'b01, 6, 1'b1, 16'h1234);
      settle();
      select();
      chk("R10 no status after cycle end", {15'd0, sdo_en}, 16'd0);
      deselect();

      phase = "R3 streaming";
      do_read(5, 2, 0);
      chk("R3 first word", rbuf[0], 16'hA5C3);
      chk("R3 next word without zero", rbuf[1], 16'h1234);
      prog(2'b01, DEPTH - 1, 1'b1, 16'h0F0F);
      settle();
      do_read(DEPTH - 1, 2, 0);
      chk("R3 last word", rbuf[0], 16'h0F0F);
      chk("R3 wrap to word 0", rbuf[1], 16'hFFFF);

      phase = "R6 erase";
      prog(2'b11, 5, 1'b0, '0);
      settle();
      do_read(5, 2, 0);
      chk("R6 erased word", rbuf[0], 16'hFFFF);
      chk("R6 neighbour kept", rbuf[1], 16'h1234);

      phase = "R11 abort";
      select();
      send_hdr(2'b01, 6);
      for (int i = 0; i < 8; i++) clk_bit(1'b0);
      deselect();
      select();
      chk("R11 no cycle after abort", {15'd0, sdo_en}, 16'd0);
      deselect();
      do_read(6, 1, 0);
      chk("R11 word kept after abort", rbuf[0], 16'h1234);

      phase = "R1 leading zeros";
      do_read(6, 1, 3);
      chk("R1 zeros before start bit", rbuf[0], 16'h1234);

      phase = "R7 fill and wipe";
      prog(2'b00, ext_addr(1), 1'b1, 16'h5A5A);
      settle();
      do_read(0, 1, 0);
      chk("R7 fill word 0", rbuf[0], 16'h5A5A);
      do_read(777, 1, 0);
      chk("R7 fill word 777", rbuf[0], 16'h5A5A);
      prog(2'b00, ext_addr(2), 1'b0, '0);
      settle();
      do_read(777, 1, 0);
      chk("R7 wipe word 777", rbuf[0], 16'hFFFF);

      phase = "R4 lock";
      prog(2'b00, ext_addr(0), 1'b0, '0);
      prog(2'b01, 3, 1'b1, 16'h0000);
      settle();
      do_read(3, 1, 0);
      chk("R4 write blocked after lock", rbuf[0], 16'hFFFF);
      prog(2'b00, ext_addr(1), 1'b1, 16'h0101);
      settle();
      do_read(3, 1, 0);
      chk("R8 fill blocked after lock", rbuf[0], 16'hFFFF);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

endmodule